// File: doc/BRIEF.md
# Coarse DAC Frequency Search

This block sets the control DAC of a disciplined oscillator close to frequency before a fine phase-tracking loop takes over. After reset the DAC code sits at mid-scale. Each time a new measurement arrives, the block classes it as fast, slow or on frequency. The measurement is the oscillator count taken over one reference second, truncated to 16 bits. The block then moves the DAC code by the current step and halves the step for the next decision.

The decision uses only the low 16 bits of the per-second count. The block compares them with the nominal count truncated the same way. The default nominal is 16'h9680, the low half of ten million. The true count never has to be accumulated, because within the oscillator's pull range no other value shares those low bits.

Once the step has shrunk to its floor, the block counts measurements that leave the DAC code unchanged. After a fixed dwell of such measurements it raises a ready flag. The flag hands control to the fine loop and freezes the search.

Top module: `dac_bsearch_cal`

## Requirements
- R1: After reset the DAC code is mid-scale (12'h800 with default parameters), the step is 8'h80 and the ready flag is low.
- R2: On an accepted measurement, a delta above 16'h9680 (oscillator fast) lowers the DAC code by the current step. A delta below it raises the code by the current step. This applies with the default polarity; a parameter reverses it.
- R3: A delta equal to 16'h9680 leaves the DAC code unchanged but still halves the step.
- R4: Each accepted measurement halves the step (0x80, 0x40, 0x20, 0x10, 0x08, 0x04) until it reaches the floor of 0x04. It then stays at the floor.
- R5: The DAC code saturates at 12'hFFF and at 12'h000 and never wraps. A measurement clamped at a bound that leaves the code unchanged counts as no change.
- R6: The ready flag rises on the 256th consecutive accepted measurement that is made at the floor step and leaves the DAC code unchanged. Two things restart the count: any code change, and any measurement made above the floor.
- R7: Once raised, the ready flag stays high until reset. Measurements that arrive while it is high change neither the DAC code nor the step.
- R8: Without a measurement strobe, the DAC code and the step hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| meas_vld_i | input | 1 | One-cycle strobe: a new per-second count delta is valid |
| delta_i | input | 16 | Low 16 bits of the per-second oscillator count |
| dac_o | output | 12 | DAC control code |
| lock_o | output | 1 | Search finished; enables the fine loop |
| step_o | output | 8 | Step size the next decision will apply |

## Verification
The first pattern is a run of fast-only readings, which walks the code down through every step size. It shows the halving sequence and the floor. A mixed run uses the counts one below and one above nominal, plus the exact nominal. It separates the three decision classes at their closest points and shows that an on-frequency reading halves the step without moving the code. Long one-sided runs drive the code into both rails, which exposes any wrap and shows that a clamped reading counts toward the dwell. Runs of nominal readings, including one interrupted by a single correction, pin the exact measurement on which the handoff fires and show that readings are ignored after it.

// File: rtl/dac_cal_pkg.sv
package dac_cal_pkg;
  typedef enum logic [1:0] {
    CMP_BELOW = 2'd0,
    CMP_EQUAL = 2'd1,
    CMP_ABOVE = 2'd2
  } cmp_e;
endpackage

// File: rtl/dac_cal_cmp.sv
module dac_cal_cmp
  import dac_cal_pkg::*;
#(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] NOMINAL = 16'h9680
) (
  input  logic [CNT_W-1:0] delta_i,
  output cmp_e             cmp_o
);
  localparam logic [CNT_W-1:0] NOM = CNT_W'(NOMINAL);

  // modular compare on truncated count; wrap ambiguity is outside pull range
  always_comb begin
    if (delta_i > NOM)      cmp_o = CMP_ABOVE;
    else if (delta_i < NOM) cmp_o = CMP_BELOW;
    else                    cmp_o = CMP_EQUAL;
  end
endmodule

// File: rtl/dac_cal_step.sv
module dac_cal_step #(
  parameter int STEP_INIT = 128,
  parameter int STEP_MIN  = 4,
  parameter int STEP_W    = $clog2(STEP_INIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [STEP_W-1:0] step_o,
  output logic              at_min_o
);
  localparam logic [STEP_W-1:0] S_INIT = STEP_W'(STEP_INIT);
  localparam logic [STEP_W-1:0] S_MIN  = STEP_W'(STEP_MIN);

  logic [STEP_W-1:0] step_q, half;

  always_comb begin
    half     = step_q >> 1;
    at_min_o = (step_q <= S_MIN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  step_q <= S_INIT;
    else if (adv_i && !at_min_o)  step_q <= (half < S_MIN) ? S_MIN : half;
  end

  assign step_o = step_q;
endmodule

// File: rtl/dac_cal_acc.sv
module dac_cal_acc
  import dac_cal_pkg::*;
#(
  parameter int DAC_W   = 12,
  parameter int STEP_W  = 8,
  parameter bit FAST_DN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  cmp_e              cmp_i,
  input  logic [STEP_W-1:0] step_i,
  output logic [DAC_W-1:0]  dac_o,
  output logic              moved_o
);
  localparam logic [DAC_W-1:0] MID  = {1'b1, {(DAC_W-1){1'b0}}};
  localparam logic [DAC_W-1:0] MAXV = '1;

  logic [DAC_W-1:0] dac_q, dac_nxt, step_x;
  logic [DAC_W:0]   sum;
  logic             go_up, go_dn;

  always_comb begin
    step_x = {{(DAC_W-STEP_W){1'b0}}, step_i};
    if (FAST_DN) begin
      go_up = (cmp_i == CMP_BELOW);
      go_dn = (cmp_i == CMP_ABOVE);
    end else begin
      go_up = (cmp_i == CMP_ABOVE);
      go_dn = (cmp_i == CMP_BELOW);
    end
    sum     = {1'b0, dac_q} + {1'b0, step_x};
    dac_nxt = dac_q;
    if (go_up)      dac_nxt = sum[DAC_W] ? MAXV : sum[DAC_W-1:0];
    else if (go_dn) dac_nxt = (dac_q < step_x) ? '0 : dac_q - step_x;
    moved_o = upd_i && (dac_nxt != dac_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    dac_q <= MID;
    else if (upd_i) dac_q <= dac_nxt;
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/dac_cal_dwell.sv
module dac_cal_dwell #(
  parameter int DWELL = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic hit_o
);
  localparam int CW = $clog2(DWELL + 1);
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (clr_i)                        cnt_q <= '0;
    else if (tick_i && cnt_q != CW'(DWELL)) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dac_bsearch_cal.sv
module dac_bsearch_cal
  import dac_cal_pkg::*;
#(
  parameter int          DAC_W     = 12,
  parameter int          CNT_W     = 16,
  parameter logic [15:0] NOMINAL   = 16'h9680,
  parameter int          STEP_INIT = 128,
  parameter int          STEP_MIN  = 4,
  parameter int          DWELL     = 256,
  parameter bit          FAST_DN   = 1'b1,
  localparam int         STEP_W    = $clog2(STEP_INIT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              meas_vld_i,
  input  logic [CNT_W-1:0]  delta_i,
  output logic [DAC_W-1:0]  dac_o,
  output logic              lock_o,
  output logic [STEP_W-1:0] step_o
);
  cmp_e cmp;
  logic accept, at_min, moved, hit, lock_q;

  assign accept = meas_vld_i && !lock_q;

  dac_cal_cmp #(.CNT_W(CNT_W), .NOMINAL(NOMINAL)) u_cmp (
    .delta_i (delta_i),
    .cmp_o   (cmp)
  );

  dac_cal_step #(.STEP_INIT(STEP_INIT), .STEP_MIN(STEP_MIN), .STEP_W(STEP_W)) u_step (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .adv_i    (accept),
    .step_o   (step_o),
    .at_min_o (at_min)
  );

  dac_cal_acc #(.DAC_W(DAC_W), .STEP_W(STEP_W), .FAST_DN(FAST_DN)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .upd_i   (accept),
    .cmp_i   (cmp),
    .step_i  (step_o),
    .dac_o   (dac_o),
    .moved_o (moved)
  );

  // dwell only counts quiet decisions at the floor step
  dac_cal_dwell #(.DWELL(DWELL)) u_dwell (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (accept && at_min && !moved),
    .clr_i  (accept && (moved || !at_min)),
    .hit_o  (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  lock_q <= 1'b0;
    else if (hit) lock_q <= 1'b1;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/dac_bsearch_cal_chk.sv
module dac_bsearch_cal_chk #(
  parameter int DAC_W    = 12,
  parameter int STEP_W   = 8,
  parameter int STEP_MIN = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              meas_vld_i,
  input logic [DAC_W-1:0]  dac_o,
  input logic              lock_o,
  input logic [STEP_W-1:0] step_o
);
  logic [DAC_W-1:0] step_x;
  assign step_x = {{(DAC_W-STEP_W){1'b0}}, step_o};

  // R7
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  // R7
  locked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> ($stable(dac_o) && $stable(step_o)));

  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !meas_vld_i |=> ($stable(dac_o) && $stable(step_o)));

  // R4
  step_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o >= STEP_W'(STEP_MIN)) && $onehot(step_o));

  // R4
  step_halve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && !lock_o && step_o > STEP_W'(STEP_MIN))
      |=> (step_o == ($past(step_o) >> 1)));

  // R2
  dac_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (meas_vld_i && !lock_o)
      |=> (((dac_o >= $past(dac_o)) ? (dac_o - $past(dac_o))
                                     : ($past(dac_o) - dac_o)) <= $past(step_x)));
endmodule

bind dac_bsearch_cal dac_bsearch_cal_chk #(
  .DAC_W(DAC_W), .STEP_W(STEP_W), .STEP_MIN(STEP_MIN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .meas_vld_i(meas_vld_i),
  .dac_o(dac_o), .lock_o(lock_o), .step_o(step_o)
);

// File: tb/dac_bsearch_cal_tb_top.sv
module dac_bsearch_cal_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] NOM  = 16'h9680;
  localparam logic [15:0] FAST = 16'h9681;
  localparam logic [15:0] SLOW = 16'h967F;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        meas_vld = 1'b0;
  logic [15:0] delta = '0;
  logic [11:0] dac;
  logic        lock;
  logic [7:0]  step;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_bsearch_cal dut_i (
    .clk_i(clk), .rst_ni(rst_n), .meas_vld_i(meas_vld), .delta_i(delta),
    .dac_o(dac), .lock_o(lock), .step_o(step)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    meas_vld = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic strobe(input logic [15:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      meas_vld = 1'b1;
      delta = d;
      @(negedge clk);
      meas_vld = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 dac", dac, 12'h800);
    check("R1 step", step, 8'h80);
    check("R1 lock", lock, 0);
  endtask

  task automatic t_fast_walk();
    logic [11:0] e_dac = 12'h800;
    logic [7:0]  e_step = 8'h80;
    do_reset();
    for (int i = 0; i < 7; i++) begin
      strobe(FAST, 1);
      e_dac = e_dac - {4'h0, e_step};
      if (e_step > 8'h04) e_step = e_step >> 1;
      check("R2 fast lowers dac", dac, e_dac);
      check("R4 step halving/floor", step, e_step);
    end
  endtask

  task automatic t_mixed();
    do_reset();
    strobe(SLOW, 1);
    check("R2 slow raises dac", dac, 12'h880);
    strobe(FAST, 1);
    check("R2 fast lowers dac", dac, 12'h840);
    strobe(NOM, 1);
    check("R3 equal holds dac", dac, 12'h840);
    check("R3 equal halves step", step, 8'h10);
    repeat (5) @(negedge clk);
    check("R8 idle dac", dac, 12'h840);
    check("R8 idle step", step, 8'h10);
  endtask

  task automatic t_sat_high();
    do_reset();
    strobe(SLOW, 454);
    check("R5 near top", dac, 12'hFFC);
    strobe(SLOW, 1);
    check("R5 clamp top", dac, 12'hFFF);
    strobe(SLOW, 255);
    check("R5 no wrap top", dac, 12'hFFF);
    check("R6 clamped not yet ready", lock, 0);
    strobe(SLOW, 1);
    check("R6 clamped ready", lock, 1);
  endtask

  task automatic t_sat_low();
    do_reset();
    strobe(FAST, 454);
    check("R5 near bottom", dac, 12'h004);
    strobe(FAST, 1);
    check("R5 reach zero", dac, 12'h000);
    strobe(FAST, 3);
    check("R5 no wrap bottom", dac, 12'h000);
  endtask

  task automatic t_lock();
    do_reset();
    strobe(NOM, 5);
    check("R4 floor reached", step, 8'h04);
    strobe(NOM, 255);
    check("R6 not ready at 255", lock, 0);
    strobe(NOM, 1);
    check("R6 ready at 256", lock, 1);
    strobe(FAST, 1);
    check("R7 dac frozen", dac, 12'h800);
    check("R7 step frozen", step, 8'h04);
    check("R7 lock held", lock, 1);
  endtask

  task automatic t_restart();
    do_reset();
    strobe(NOM, 105);
    strobe(FAST, 1);
    check("R6 correction applied", dac, 12'h7FC);
    strobe(NOM, 255);
    check("R6 restart not ready", lock, 0);
    strobe(NOM, 1);
    check("R6 restart ready", lock, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fast_walk();
    t_mixed();
    t_sat_high();
    t_sat_low();
    t_lock();
    t_restart();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule